// File: doc/BRIEF.md
# Input Change Interrupt Unit

This unit monitors a small group of digital input lines and raises a per-line status flag whenever an enabled line changes level. The change can be rising or falling. A single level interrupt request is formed from those flags. The request may share a wire with other devices, so a status read of zero tells the host that this unit is not asking for service. The host clears flags by writing a clear mask.

Each line has its own enable bit. Disabling a line does not throw its history away. At the moment of disabling, the unit stores that line's level. When the line is enabled again, its flag is raised only if the level now differs from the stored one. As a result, an even number of toggles while disabled leaves no trace, while an odd number produces one interrupt.

Access is through a small register window of 16-bit words:

| Byte offset | Register |
|---|---|
| 0 | Status (read) |
| 2 | Enable (read and write) |
| 4 | Clear mask (write) |
| 6 | Synchronized level (read) |

Top module: `fin_chg_irq`

## Requirements
- R1: After reset, every status bit reads 0, the enable register reads 0x0000 and `irq` is low.
- R2: For an enabled channel i, a rising or a falling change of `pin_in[i]` sets status bit i at offset 0. The bit is set three clock edges after the pin changes: two synchronizer stages, then the status register.
- R3: A channel whose enable bit is 0 sets no status bit on input changes, and its status bit reads 0.
- R4: A 1-to-0 write of enable bit i stores the synchronized level of line i. A later 0-to-1 write sets status bit i only if the current level differs from the stored one, so an even number of toggles gives no status and an odd number gives status.
- R5: Writing to offset 4 clears each status bit whose write-data bit is 1 and leaves the others. A value of 0x00FF clears all eight bits.
- R6: When a clear write and a new change on channel i take effect on the same clock edge, status bit i ends up set.
- R7: `irq` is the OR of the status bits. It follows them one clock later, so it is low exactly when a status read would return zero.
- R8: Writing enable bit i from 1 to 0 clears status bit i. Re-enabling with the level unchanged leaves the bit at 0.
- R9: Offset 2 holds an 8-bit enable register in bits 7:0, and bits 15:8 read as zero.
- R10: Offset 6 returns the two-stage synchronized input levels in bits 7:0. A read taken in the cycle after a pin change still returns the old level.
- R11: Read data appears on `rdata` on the clock edge that samples `rd_en`. Writes to offsets 0 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_CH | Asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A pin change reaches the status register on the third rising edge after it is driven. It reaches `irq` on the fourth, and a status read issued after the third edge returns the value on the fourth. The bench drives pins and strobes on falling edges and waits four falling edges before it reads status or samples `irq`. Enable and clear writes take effect on the single edge that samples them. The same-edge race between a clear and a change is built by issuing the clear exactly two falling edges after the pin moves. The synchronizer delay is probed by reading the level register one cycle too early and then again one cycle later.

// File: rtl/fin_pkg.sv
package fin_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 3'd6;
endpackage

// File: rtl/fin_sync.sv
module fin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fin_chan.sv
module fin_chan (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic lvl_prev,
  input  logic en_q,
  input  logic en_wr,
  input  logic en_new,
  input  logic clr,
  output logic st
);
  logic cap;
  logic chg;
  logic going_off;
  logic going_on;

  assign chg       = lvl ^ lvl_prev;
  assign going_off = en_wr & en_q & ~en_new;
  assign going_on  = en_wr & ~en_q & en_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= 1'b0;
      cap <= 1'b0;
    end else begin
      if (going_off) cap <= lvl;
      if (going_off)     st <= 1'b0;
      else if (going_on) st <= (lvl != cap);
      else if (en_q)     st <= chg | (st & ~clr);
      else               st <= 1'b0;
    end
  end

  // R3: a line that stays disabled keeps its flag low
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !en_wr) |=> !st);
  // R2: a change on an enabled line raises the flag
  a_r2_change_sets: assert property (@(posedge clk) disable iff (rst)
    (en_q && !en_wr && chg) |=> st);
  // R6: a change wins over a same-edge clear
  a_r6_change_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (en_q && !en_wr && chg && clr) |=> st);
  // R5: a clear with no change drops the flag
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (en_q && !en_wr && clr && !chg) |=> !st);
  // R4: re-enable at the stored level gives no flag
  a_r4_same_level_quiet: assert property (@(posedge clk) disable iff (rst)
    (going_on && lvl == cap) |=> !st);
  // R8: disabling clears the flag
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
    going_off |=> !st);
endmodule

// File: rtl/fin_regs.sv
module fin_regs
  import fin_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_CH-1:0]   wlow,
  input  logic [N_CH-1:0]   lvl,
  input  logic [N_CH-1:0]   st_vec,
  output logic [N_CH-1:0]   en_q,
  output logic              en_wr,
  output logic [N_CH-1:0]   en_new,
  output logic [N_CH-1:0]   clr_vec,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int PAD = DATA_W - N_CH;

  logic [N_CH-1:0] st_vis;

  assign en_wr   = wr_en && (addr == OFS_ENABLE);
  assign en_new  = wlow;
  assign clr_vec = (wr_en && (addr == OFS_CLEAR)) ? wlow : '0;
  assign st_vis  = st_vec & en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (en_wr) en_q <= en_new;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        OFS_STATUS: rdata <= {{PAD{1'b0}}, st_vis};
        OFS_ENABLE: rdata <= {{PAD{1'b0}}, en_q};
        OFS_LEVEL:  rdata <= {{PAD{1'b0}}, lvl};
        default:    rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |st_vis;
  end

  // R7: request follows the flags one clock later
  a_r7_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|st_vec) |=> irq);
  a_r7_irq_low: assert property (@(posedge clk) disable iff (rst)
    (st_vec == '0) |=> !irq);
  // R9: enable register takes the written low byte
  a_r9_enable_load: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> (en_q == $past(wlow)));
  // R11: other offsets leave the enable register alone
  a_r11_enable_hold: assert property (@(posedge clk) disable iff (rst)
    !en_wr |=> $stable(en_q));
endmodule

// File: rtl/fin_chg_irq.sv
module fin_chg_irq
  import fin_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   pin_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [N_CH-1:0] lvl;
  logic [N_CH-1:0] lvl_prev;
  logic [N_CH-1:0] st_vec;
  logic [N_CH-1:0] en_q;
  logic [N_CH-1:0] en_new;
  logic [N_CH-1:0] clr_vec;
  logic            en_wr;
  logic            unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:N_CH];

  fin_sync #(.W(N_CH), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= '0;
    else     lvl_prev <= lvl;
  end

  fin_regs #(.N_CH(N_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wlow(wdata[N_CH-1:0]), .lvl(lvl), .st_vec(st_vec), .en_q(en_q),
    .en_wr(en_wr), .en_new(en_new), .clr_vec(clr_vec), .rdata(rdata),
    .irq(irq)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    fin_chan u_ch (
      .clk(clk), .rst(rst), .lvl(lvl[i]), .lvl_prev(lvl_prev[i]),
      .en_q(en_q[i]), .en_wr(en_wr), .en_new(en_new[i]),
      .clr(clr_vec[i]), .st(st_vec[i])
    );
  end
endmodule

// File: tb/fin_chg_irq_test.sv
module fin_chg_irq_test;
  import fin_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fin_chg_irq uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // {pin value, expected status}, enable = 0xFF, cleared after each
  localparam logic [15:0] VEC [6] = '{
    16'h01_01, 16'h81_80, 16'h7E_FF, 16'h7E_00, 16'h00_7E, 16'hA5_A5
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rd(OFS_STATUS, d); check("R1 status", d, 16'h0000);
    rd(OFS_ENABLE, d); check("R1 enable", d, 16'h0000);

    // R2/R7 vector walk
    wr(OFS_ENABLE, 16'h00FF);
    foreach (VEC[k]) begin
      pin_in = VEC[k][15:8];
      settle();
      rd(OFS_STATUS, d); check("R2 status", d, {8'h00, VEC[k][7:0]});
      check("R7 irq", {15'd0, irq}, {15'd0, VEC[k][7:0] != 8'h00});
      wr(OFS_CLEAR, 16'h00FF);
      @(negedge clk);
    end

    // R5 partial clear
    pin_in = 8'h5A; settle();
    wr(OFS_CLEAR, 16'h000F);
    rd(OFS_STATUS, d); check("R5 partial", d, 16'h00F0);
    wr(OFS_CLEAR, 16'h00FF);
    rd(OFS_STATUS, d); check("R5 all", d, 16'h0000);

    // R6 change on the clearing edge
    pin_in = 8'h58;
    @(negedge clk); @(negedge clk);
    wr(OFS_CLEAR, 16'h00FF);
    rd(OFS_STATUS, d); check("R6 change wins", d, 16'h0002);
    check("R7 irq set", {15'd0, irq}, 16'h0001);
    wr(OFS_CLEAR, 16'h00FF);
    @(negedge clk);
    check("R7 irq clear", {15'd0, irq}, 16'h0000);

    // R10 level register and its latency
    pin_in = 8'h81;
    @(negedge clk);
    rd(OFS_LEVEL, d); check("R10 early", d, 16'h0058);
    rd(OFS_LEVEL, d); check("R10 level", d, 16'h0081);
    settle();
    wr(OFS_CLEAR, 16'h00FF);

    // R9 enable register width
    wr(OFS_ENABLE, 16'hFF3C);
    rd(OFS_ENABLE, d); check("R9 enable", d, 16'h003C);
    // R11 writes to status and level ignored
    wr(OFS_STATUS, 16'hFFFF);
    wr(OFS_LEVEL, 16'hFFFF);
    rd(OFS_ENABLE, d); check("R11 enable kept", d, 16'h003C);
    rd(OFS_STATUS, d); check("R11 status kept", d, 16'h0000);
    rd(OFS_LEVEL, d); check("R11 level kept", d, 16'h0081);

    // R3/R4 disabled line, even then odd toggles
    wr(OFS_ENABLE, 16'h00FF);
    pin_in = 8'h00; settle();
    wr(OFS_CLEAR, 16'h00FF);
    wr(OFS_ENABLE, 16'h00F7);
    pin_in = 8'h08; settle();
    rd(OFS_STATUS, d); check("R3 disabled", d, 16'h0000);
    check("R3 irq", {15'd0, irq}, 16'h0000);
    pin_in = 8'h00; settle();
    wr(OFS_ENABLE, 16'h00FF);
    rd(OFS_STATUS, d); check("R4 even", d, 16'h0000);
    wr(OFS_ENABLE, 16'h00F7);
    pin_in = 8'h08; settle();
    wr(OFS_ENABLE, 16'h00FF);
    rd(OFS_STATUS, d); check("R4 odd", d, 16'h0008);
    check("R4 irq", {15'd0, irq}, 16'h0001);

    // R8 disable clears, re-enable at same level stays clear
    wr(OFS_ENABLE, 16'h00F7);
    rd(OFS_STATUS, d); check("R8 disabled", d, 16'h0000);
    wr(OFS_ENABLE, 16'h00FF);
    rd(OFS_STATUS, d); check("R8 reenable", d, 16'h0000);

    if (!done) begin
      done = 1;
      finish_run();
    end
  end
endmodule